// File: doc/BRIEF.md
# Reservation Station Array with Result-Bus Operand Capture

This block holds operations that have been issued but not yet executed in a speculative out-of-order core. Each issued operation comes with two sources. A source is either a value that is already known, taken from the register file or from a finished reorder-buffer entry, or the reorder-buffer index of the instruction that will produce it. The operation also carries the reorder-buffer index that was allocated for its own result. That index later labels the result when it is broadcast.

Every waiting source watches the common result bus. When the broadcast index matches the one the source waits on, the source latches the broadcast value. An operation whose two sources both hold values is ready. Each cycle the lowest-numbered ready station is sent to the functional unit with both values and its destination index, and that station becomes free again. A flush input empties every station in one cycle, which is used after a mispredicted branch. The functional unit and the reorder buffer are outside this block.

Top module: `rs_array`

## Requirements
- R1: `iss_ready` is high exactly when no flush is requested, `rob_free` is high and at least one station is empty. An issue is accepted only on a cycle where `iss_valid` and `iss_ready` are both high. With all stations occupied, or with `rob_free` low, nothing is accepted.
- R2: A source issued with its held flag set to 1 keeps the supplied value. That value appears unchanged on `disp_a` or `disp_b` when the operation is dispatched, together with its `disp_op`.
- R3: A source issued with its held flag at 0 waits on its tag. It latches `cdb_data` on the first cycle that `cdb_valid` is high with `cdb_tag` equal to that tag. Broadcasts carrying any other tag leave it waiting.
- R4: `disp_valid` is high only for an operation whose two sources both hold values. `disp_dst` carries the reorder-buffer index given at issue.
- R5: At most one operation is dispatched per cycle, and it is the ready one in the lowest-numbered station. Its station is empty from the next cycle onward.
- R6: A broadcast on the same cycle as an accepted issue is forwarded into the new entry when its tag matches a waiting source. If that makes both sources held, the entry is dispatchable on the following cycle.
- R7: With `flush` high, no issue is accepted and nothing is dispatched. From the next cycle every station is empty, and broadcasts for the discarded entries cause no dispatch.
- R8: After reset every station is empty, `disp_valid` is low, and `iss_ready` follows `rob_free`.
- R9: An accepted operation is written into the lowest-numbered empty station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all stations this cycle |
| rob_free | input | 1 | Reorder buffer has a free slot |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Operation code carried to the functional unit |
| iss_a_held | input | 1 | 1: `iss_a_val` is the value; 0: wait on `iss_a_tag` |
| iss_a_tag | input | TAG_W | Producer index for source A |
| iss_a_val | input | DATA_W | Value for source A |
| iss_b_held | input | 1 | 1: `iss_b_val` is the value; 0: wait on `iss_b_tag` |
| iss_b_tag | input | TAG_W | Producer index for source B |
| iss_b_val | input | DATA_W | Value for source B |
| iss_dst | input | TAG_W | Reorder-buffer index allocated for the result |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Index of the broadcast result |
| cdb_data | input | DATA_W | Broadcast value |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_op | output | OP_W | Dispatched operation code |
| disp_a | output | DATA_W | Dispatched source A value |
| disp_b | output | DATA_W | Dispatched source B value |
| disp_dst | output | TAG_W | Dispatched destination index |

## Verification
The bench builds the block with its defaults: four stations, 3-bit tags, 16-bit data and 4-bit operation codes. With only eight tag values, random broadcasts often hit waiting sources, and they often hit a source in the very cycle it is issued. Four stations fill within a few cycles of steady issue, so the full-array stall, several ready entries competing, and a flush over a partly filled array all come up often alongside the directed cases.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Whether a source operand holds its value or is still waiting on a tag
    typedef enum logic {
        OPND_PENDING = 1'b0,
        OPND_HELD    = 1'b1
    } opnd_state_e;

    // Per-station control produced by the array for one cycle
    typedef struct packed {
        logic kill;   // flush: drop the entry
        logic wr;     // accept a new operation into this station
        logic clr;    // entry dispatched, release the station
    } slot_ctl_t;

    function automatic logic slot_ready(input logic busy, input logic a_held, input logic b_held);
        return busy && a_held && b_held;
    endfunction

endpackage

// File: rtl/rs_lowest_pick.sv
module rs_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/rs_operand.sv
module rs_operand
    import rs_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              kill,
    input  logic              load,
    input  logic              active,
    input  logic              in_held,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              held,
    output logic [DATA_W-1:0] data
);
    opnd_state_e       st;
    logic [TAG_W-1:0]  wait_tag;
    logic              hit_new;
    logic              hit_wait;

    assign hit_new  = cdb_valid && (cdb_tag == in_tag);
    assign hit_wait = active && (st == OPND_PENDING) && cdb_valid && (cdb_tag == wait_tag);
    assign held     = (st == OPND_HELD);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            st       <= OPND_PENDING;
            wait_tag <= '0;
            data     <= '0;
        end else if (load) begin
            wait_tag <= in_tag;
            if (in_held) begin
                st   <= OPND_HELD;
                data <= in_val;
            end else if (hit_new) begin
                st   <= OPND_HELD;
                data <= cdb_data;
            end else begin
                st   <= OPND_PENDING;
                data <= '0;
            end
        end else if (hit_wait) begin
            st   <= OPND_HELD;
            data <= cdb_data;
        end
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (hit_wait && !kill && !load) |=> (held && data == $past(cdb_data)));

    assert_keep_held_R2: assert property (@(posedge clk) disable iff (rst)
        (held && !kill && !load) |=> (held && $stable(data)));

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_ctl_t         ctl,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_a_held,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic              in_b_held,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_data,
    output logic [DATA_W-1:0] b_data
);
    logic a_held;
    logic b_held;

    always_ff @(posedge clk) begin
        if (rst || ctl.kill) begin
            busy <= 1'b0;
            op   <= '0;
            dst  <= '0;
        end else if (ctl.wr) begin
            busy <= 1'b1;
            op   <= in_op;
            dst  <= in_dst;
        end else if (ctl.clr) begin
            busy <= 1'b0;
        end
    end

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_a (
        .clk(clk), .rst(rst), .kill(ctl.kill), .load(ctl.wr), .active(busy),
        .in_held(in_a_held), .in_tag(in_a_tag), .in_val(in_a_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .held(a_held), .data(a_data)
    );

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src_b (
        .clk(clk), .rst(rst), .kill(ctl.kill), .load(ctl.wr), .active(busy),
        .in_held(in_b_held), .in_tag(in_b_tag), .in_val(in_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .held(b_held), .data(b_data)
    );

    assign ready = slot_ready(busy, a_held, b_held);

    assert_write_free_R1: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |-> !busy);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr && !ctl.wr) |=> !busy);

endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int NUM_RS = 4,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              rob_free,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_held,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_held,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_dst,
    output logic              iss_ready,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_dst
);
    logic [NUM_RS-1:0] busy_vec;
    logic [NUM_RS-1:0] ready_vec;
    logic [NUM_RS-1:0] alloc_gnt;
    logic [NUM_RS-1:0] disp_gnt;
    logic              any_free;
    logic              any_ready;
    logic              accept;

    logic [OP_W-1:0]   s_op   [NUM_RS];
    logic [TAG_W-1:0]  s_dst  [NUM_RS];
    logic [DATA_W-1:0] s_a    [NUM_RS];
    logic [DATA_W-1:0] s_b    [NUM_RS];

    rs_lowest_pick #(.N(NUM_RS)) u_alloc_pick (
        .req(~busy_vec), .gnt(alloc_gnt), .any(any_free)
    );

    rs_lowest_pick #(.N(NUM_RS)) u_disp_pick (
        .req(ready_vec), .gnt(disp_gnt), .any(any_ready)
    );

    assign iss_ready  = !flush && rob_free && any_free;
    assign accept     = iss_valid && iss_ready;
    assign disp_valid = !flush && any_ready;

    for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
        slot_ctl_t ctl;
        assign ctl.kill = flush;
        assign ctl.wr   = accept && alloc_gnt[i];
        assign ctl.clr  = disp_valid && disp_gnt[i];

        rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst(rst), .ctl(ctl),
            .in_op(iss_op),
            .in_a_held(iss_a_held), .in_a_tag(iss_a_tag), .in_a_val(iss_a_val),
            .in_b_held(iss_b_held), .in_b_tag(iss_b_tag), .in_b_val(iss_b_val),
            .in_dst(iss_dst),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
            .busy(busy_vec[i]), .ready(ready_vec[i]),
            .op(s_op[i]), .dst(s_dst[i]), .a_data(s_a[i]), .b_data(s_b[i])
        );
    end

    always_comb begin
        disp_op  = '0;
        disp_dst = '0;
        disp_a   = '0;
        disp_b   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (disp_gnt[i]) begin
                disp_op  = s_op[i];
                disp_dst = s_dst[i];
                disp_a   = s_a[i];
                disp_b   = s_b[i];
            end
        end
    end

    assert_disp_ready_R4: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((ready_vec & disp_gnt) != '0));

    assert_single_disp_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_gnt));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy_vec == '0));

    assert_alloc_free_R9: assert property (@(posedge clk) disable iff (rst)
        accept |-> ((alloc_gnt & ~busy_vec) != '0));

endmodule

// File: tb/rs_array_tb.sv
module rs_array_tb;
    localparam int N = 4;
    localparam int OW = 4;
    localparam int TW = 3;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst, flush, rob_free, iss_valid, iss_a_held, iss_b_held, cdb_valid;
    logic [OW-1:0] iss_op;
    logic [TW-1:0] iss_a_tag, iss_b_tag, iss_dst, cdb_tag;
    logic [DW-1:0] iss_a_val, iss_b_val, cdb_data;
    logic iss_ready, disp_valid;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_dst;

    int checks = 0;
    int errors = 0;

    // bench model of the stations
    bit            m_busy [N];
    logic [OW-1:0] m_op   [N];
    logic [TW-1:0] m_dst  [N];
    bit            m_ah   [N];
    bit            m_bh   [N];
    logic [TW-1:0] m_at   [N];
    logic [TW-1:0] m_bt   [N];
    logic [DW-1:0] m_ad   [N];
    logic [DW-1:0] m_bd   [N];

    always #5 clk = ~clk;

    rs_array #(.NUM_RS(N), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .flush(flush), .rob_free(rob_free),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_held(iss_a_held), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_held(iss_b_held), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_dst(iss_dst), .iss_ready(iss_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_dst(disp_dst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++)
            if (m_busy[i] && m_ah[i] && m_bh[i]) return i;
        return -1;
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < N; i++)
            if (!m_busy[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_iss_ready();
        return !flush && rob_free && (lowest_free() >= 0);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_ah[i] = 0; m_bh[i] = 0;
        end
    endtask

    task automatic compare_model();
        int g;
        g = lowest_ready();
        check("R1 iss_ready", 32'(iss_ready), 32'(exp_iss_ready()));
        check("R4 disp_valid", 32'(disp_valid), 32'(!flush && g >= 0));
        if (!flush && g >= 0) begin
            check("R2 disp_op", 32'(disp_op), 32'(m_op[g]));
            check("R2 disp_a", 32'(disp_a), 32'(m_ad[g]));
            check("R2 disp_b", 32'(disp_b), 32'(m_bd[g]));
            check("R4 disp_dst", 32'(disp_dst), 32'(m_dst[g]));
        end
    endtask

    task automatic model_edge();
        int g, f;
        bit acc;
        g = lowest_ready();
        f = lowest_free();
        acc = iss_valid && exp_iss_ready();
        if (flush) begin
            model_clear();
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_busy[i] && !m_ah[i] && cdb_valid && cdb_tag == m_at[i]) begin
                    m_ah[i] = 1; m_ad[i] = cdb_data;
                end
                if (m_busy[i] && !m_bh[i] && cdb_valid && cdb_tag == m_bt[i]) begin
                    m_bh[i] = 1; m_bd[i] = cdb_data;
                end
            end
            if (g >= 0) m_busy[g] = 0;
            if (acc) begin
                m_busy[f] = 1; m_op[f] = iss_op; m_dst[f] = iss_dst;
                m_at[f] = iss_a_tag; m_bt[f] = iss_b_tag;
                m_ah[f] = iss_a_held || (cdb_valid && cdb_tag == iss_a_tag);
                m_ad[f] = iss_a_held ? iss_a_val : cdb_data;
                m_bh[f] = iss_b_held || (cdb_valid && cdb_tag == iss_b_tag);
                m_bd[f] = iss_b_held ? iss_b_val : cdb_data;
            end
        end
    endtask

    task automatic idle_inputs();
        flush = 0; rob_free = 1; iss_valid = 0; cdb_valid = 0;
        iss_op = '0; iss_a_held = 0; iss_b_held = 0;
        iss_a_tag = '0; iss_b_tag = '0; iss_a_val = '0; iss_b_val = '0;
        iss_dst = '0; cdb_tag = '0; cdb_data = '0;
    endtask

    // one clock: compare, take the edge, update model, return to idle inputs
    task automatic cyc();
        #1;
        compare_model();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic drive_issue(input logic [OW-1:0] op, input bit ah, input logic [TW-1:0] at,
                               input logic [DW-1:0] av, input bit bh, input logic [TW-1:0] bt,
                               input logic [DW-1:0] bv, input logic [TW-1:0] dst);
        iss_valid = 1; iss_op = op;
        iss_a_held = ah; iss_a_tag = at; iss_a_val = av;
        iss_b_held = bh; iss_b_tag = bt; iss_b_val = bv;
        iss_dst = dst;
    endtask

    task automatic drive_bus(input logic [TW-1:0] t, input logic [DW-1:0] d);
        cdb_valid = 1; cdb_tag = t; cdb_data = d;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        model_clear();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R8: reset state
        check("R8 disp_valid", 32'(disp_valid), 32'd0);
        check("R8 iss_ready", 32'(iss_ready), 32'd1);
        rob_free = 0; #1;
        check("R8 iss_ready follows rob_free", 32'(iss_ready), 32'd0);
        // R1: no reorder slot blocks issue
        iss_valid = 1; iss_a_held = 1; iss_b_held = 1;
        cyc();
        check("R1 no issue without reorder slot", 32'(disp_valid), 32'd0);

        // R2 R4: both sources held
        drive_issue(4'h3, 1, 3'd0, 16'h1111, 1, 3'd0, 16'h2222, 3'd5);
        cyc();
        check("R4 ready entry dispatched", 32'(disp_valid), 32'd1);
        check("R2 held value A", 32'(disp_a), 32'h1111);
        check("R2 held value B", 32'(disp_b), 32'h2222);
        check("R4 dst tag", 32'(disp_dst), 32'd5);
        cyc();
        check("R5 station released", 32'(disp_valid), 32'd0);

        // R3: waiting source ignores other tags, captures its own
        drive_issue(4'h1, 0, 3'd2, 16'h0, 1, 3'd0, 16'h0007, 3'd1);
        cyc();
        check("R4 pending not dispatched", 32'(disp_valid), 32'd0);
        drive_bus(3'd3, 16'hAAAA);
        cyc();
        check("R3 other tag ignored", 32'(disp_valid), 32'd0);
        drive_bus(3'd2, 16'hBEEF);
        cyc();
        check("R3 captured", 32'(disp_valid), 32'd1);
        check("R3 captured value", 32'(disp_a), 32'hBEEF);
        cyc();

        // R6: forward on the issue cycle
        drive_issue(4'h2, 0, 3'd4, 16'h0, 0, 3'd4, 16'h0, 3'd2);
        drive_bus(3'd4, 16'h1234);
        cyc();
        check("R6 forwarded dispatch", 32'(disp_valid), 32'd1);
        check("R6 forwarded A", 32'(disp_a), 32'h1234);
        check("R6 forwarded B", 32'(disp_b), 32'h1234);
        cyc();

        // R1 R9 R5: fill, stall, then drain in station order
        for (int k = 0; k < N; k++) begin
            drive_issue(4'(k), 0, 3'd6, 16'h0, 1, 3'd0, 16'(k), 3'(k));
            cyc();
        end
        check("R1 full stalls", 32'(iss_ready), 32'd0);
        drive_bus(3'd6, 16'h5A5A);
        cyc();
        for (int k = 0; k < N; k++) begin
            check("R5 R9 dispatch order", 32'(disp_dst), 32'(k));
            check("R5 one per cycle", 32'(disp_valid), 32'd1);
            cyc();
            check("R5 freed station issuable", 32'(iss_ready), 32'd1);
        end
        check("R5 drained", 32'(disp_valid), 32'd0);

        // R7: flush
        drive_issue(4'h7, 0, 3'd7, 16'h0, 1, 3'd0, 16'h0, 3'd3);
        cyc();
        drive_issue(4'h8, 0, 3'd7, 16'h0, 1, 3'd0, 16'h0, 3'd4);
        cyc();
        flush = 1;
        drive_issue(4'h9, 1, 3'd0, 16'h1, 1, 3'd0, 16'h2, 3'd6);
        #1;
        check("R7 no issue during flush", 32'(iss_ready), 32'd0);
        cyc();
        check("R7 empty after flush", 32'(disp_valid), 32'd0);
        drive_bus(3'd7, 16'hCAFE);
        cyc();
        check("R7 discarded entries stay gone", 32'(disp_valid), 32'd0);

        // random phase against the model
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            rob_free  = ($urandom % 8) != 0;
            flush     = ($urandom % 64) == 0;
            if ($urandom % 3 != 0)
                drive_issue(4'($urandom), ($urandom % 2) == 1, 3'($urandom), 16'($urandom),
                            ($urandom % 2) == 1, 3'($urandom), 16'($urandom), 3'($urandom));
            if ($urandom % 2 == 0)
                drive_bus(3'($urandom), 16'($urandom));
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule